// File: doc/BRIEF.md
# Function-Coded 32-bit ALU

This block is the arithmetic and logic unit of a single-cycle processor datapath. It takes two operands, a 6-bit function field, a 5-bit shift amount and a one-bit mode select from the control unit. It produces one registered result word.

When the mode select is high, the function field picks one of nine operations: add, subtract, multiply, divide, bitwise AND, bitwise OR, logical shift right, logical shift left and one's complement. The function codes follow a non-standard map. When the mode select is low, the unit always adds, whatever the function field holds. Load, store and immediate instructions use this mode to form an address or a sum.

The function field is first decoded into an enumerated operation. An arithmetic path and a logic path then each compute their candidate. The top module picks the result by operation class and captures it in an output register. That register is cleared by an active-low asynchronous reset.

Top module: `alu_fc32`

## Requirements
- R1: While `rst_n` is low, `result_o` is zero.
- R2: When `aluop_i` is 0, the result is `opa_i + opb_i` modulo 2^32, for every value of `func_i`.
- R3: With `aluop_i`=1, code 6'b100000 gives `opa_i + opb_i` and code 6'b100010 gives `opa_i - opb_i`, both modulo 2^32.
- R4: With `aluop_i`=1, code 6'b011000 gives the low 32 bits of the signed product of `opa_i` and `opb_i`.
- R5: With `aluop_i`=1, code 6'b011011 gives the signed quotient `opa_i / opb_i`, truncated toward zero (for example -7/2 = -3).
- R6: Divide with `opb_i` equal to zero gives 32'hFFFF_FFFF.
- R7: Divide of 32'h8000_0000 by 32'hFFFF_FFFF gives 32'h8000_0000.
- R8: With `aluop_i`=1, code 6'b001101 gives `opa_i & opb_i` and code 6'b001111 gives `opa_i | opb_i`.
- R9: With `aluop_i`=1, code 6'b000011 shifts `opb_i` right logically by `shamt_i`, and code 6'b000010 shifts `opb_i` left by `shamt_i`. Zeros fill the vacated bits.
- R10: With `aluop_i`=1, code 6'b001011 gives the bitwise inverse of `opb_i`.
- R11: With `aluop_i`=1, any code not listed in R3 to R10 gives zero.
- R12: The result is registered. Inputs present at a rising edge appear on `result_o` after that edge and stay until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| aluop_i | input | 1 | 1: function field selects the operation; 0: add |
| func_i | input | 6 | Function code (instruction bits 5..0) |
| shamt_i | input | 5 | Shift amount (instruction bits 10..6) |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, also the shifted and inverted operand |
| result_o | output | 32 | Registered result |

## Verification
Every result is due exactly one rising edge after its operands, function code and mode are applied. The output register is the only stage, so the latency is one cycle for every operation, the divide included. The driver sets inputs on the falling edge and queues the expected word. The monitor takes its sample 2 ns after the following rising edge and pops the queue there, so each comparison lands in the one cycle where that result is valid. The reset value is read while reset is still held, before any item is queued.

// File: rtl/alu_fc32_pkg.sv
package alu_fc32_pkg;

    localparam int FUNC_W = 6;

    localparam logic [FUNC_W-1:0] FN_ADD  = 6'b100000;
    localparam logic [FUNC_W-1:0] FN_SUB  = 6'b100010;
    localparam logic [FUNC_W-1:0] FN_MUL  = 6'b011000;
    localparam logic [FUNC_W-1:0] FN_DIV  = 6'b011011;
    localparam logic [FUNC_W-1:0] FN_AND  = 6'b001101;
    localparam logic [FUNC_W-1:0] FN_OR   = 6'b001111;
    localparam logic [FUNC_W-1:0] FN_SRL  = 6'b000011;
    localparam logic [FUNC_W-1:0] FN_SLL  = 6'b000010;
    localparam logic [FUNC_W-1:0] FN_INV  = 6'b001011;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUB,
        OP_MUL,
        OP_DIV,
        OP_AND,
        OP_OR,
        OP_SRL,
        OP_SLL,
        OP_INV,
        OP_ZERO
    } alu_op_e;

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

endpackage

// File: rtl/alu_fc32_decode.sv
module alu_fc32_decode
    import alu_fc32_pkg::*;
(
    input  logic              aluop_i,
    input  logic [FUNC_W-1:0] func_i,
    output alu_op_e           op_o
);

    always_comb begin
        if (!aluop_i) begin
            op_o = OP_ADD;
        end else begin
            unique case (func_i)
                FN_ADD:  op_o = OP_ADD;
                FN_SUB:  op_o = OP_SUB;
                FN_MUL:  op_o = OP_MUL;
                FN_DIV:  op_o = OP_DIV;
                FN_AND:  op_o = OP_AND;
                FN_OR:   op_o = OP_OR;
                FN_SRL:  op_o = OP_SRL;
                FN_SLL:  op_o = OP_SLL;
                FN_INV:  op_o = OP_INV;
                default: op_o = OP_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/alu_fc32_arith.sv
module alu_fc32_arith
    import alu_fc32_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);

    localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] prod_lo;
    logic [WIDTH-1:0] quot;
    logic [WIDTH-1:0] quot_raw;
    logic             div_zero;
    logic             div_wrap;

    // Low word of a two's complement product is sign-independent.
    assign sum      = a_i + b_i;
    assign diff     = a_i - b_i;
    assign prod_lo  = a_i * b_i;
    assign div_zero = (b_i == '0);
    assign div_wrap = (a_i == MOST_NEG) && (b_i == ALL_ONES);

    always_comb begin
        quot_raw = '0;
        if (!div_zero && !div_wrap) begin
            quot_raw = $signed(a_i) / $signed(b_i);
        end
    end

    always_comb begin
        if (div_zero)      quot = ALL_ONES;
        else if (div_wrap) quot = MOST_NEG;
        else               quot = quot_raw;
    end

    always_comb begin
        unique case (op_i)
            OP_ADD:  res_o = sum;
            OP_SUB:  res_o = diff;
            OP_MUL:  res_o = prod_lo;
            OP_DIV:  res_o = quot;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_fc32_logic.sv
module alu_fc32_logic
    import alu_fc32_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  alu_op_e            op_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [WIDTH-1:0]   res_o
);

    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_SRL:  res_o = b_i >> shamt_i;
            OP_SLL:  res_o = b_i << shamt_i;
            OP_INV:  res_o = ~b_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_fc32.sv
module alu_fc32
    import alu_fc32_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHAMT_W = $clog2(WIDTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               aluop_i,
    input  logic [FUNC_W-1:0]  func_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [WIDTH-1:0]   opa_i,
    input  logic [WIDTH-1:0]   opb_i,
    output logic [WIDTH-1:0]   result_o
);

    alu_op_e          op;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic [WIDTH-1:0] next_res;

    alu_fc32_decode u_decode (
        .aluop_i (aluop_i),
        .func_i  (func_i),
        .op_o    (op)
    );

    alu_fc32_arith #(.WIDTH(WIDTH)) u_arith (
        .op_i  (op),
        .a_i   (opa_i),
        .b_i   (opb_i),
        .res_o (arith_res)
    );

    alu_fc32_logic #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_logic (
        .op_i    (op),
        .a_i     (opa_i),
        .b_i     (opb_i),
        .shamt_i (shamt_i),
        .res_o   (logic_res)
    );

    always_comb begin
        next_res = is_arith(op) ? arith_res : logic_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result_o <= '0;
        else        result_o <= next_res;
    end

endmodule

// File: rtl/alu_fc32_chk.sv
module alu_fc32_chk #(
    parameter int WIDTH = 32,
    localparam int SHAMT_W = $clog2(WIDTH)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               aluop_i,
    input logic [5:0]         func_i,
    input logic [SHAMT_W-1:0] shamt_i,
    input logic [WIDTH-1:0]   opa_i,
    input logic [WIDTH-1:0]   opb_i,
    input logic [WIDTH-1:0]   result_o
);

    logic listed;
    assign listed = func_i inside {6'b100000, 6'b100010, 6'b011000, 6'b011011,
                                   6'b001101, 6'b001111, 6'b000011, 6'b000010,
                                   6'b001011};

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |-> (result_o == '0));

    assert_mode_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !aluop_i |=> (result_o == $past(opa_i + opb_i)));

    assert_sub_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (aluop_i && func_i == 6'b100010) |=> (result_o == $past(opa_i - opb_i)));

    assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (aluop_i && func_i == 6'b011011 && opb_i == '0) |=> (result_o == {WIDTH{1'b1}}));

    assert_and_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (aluop_i && func_i == 6'b001101) |=> (result_o == $past(opa_i & opb_i)));

    assert_inv_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (aluop_i && func_i == 6'b001011) |=> (result_o == $past(~opb_i)));

    assert_unlisted_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (aluop_i && !listed) |=> (result_o == '0));

    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(aluop_i) && $stable(func_i) && $stable(shamt_i)
         && $stable(opa_i) && $stable(opb_i)) |=> $stable(result_o));

endmodule

bind alu_fc32 alu_fc32_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .aluop_i  (aluop_i),
    .func_i   (func_i),
    .shamt_i  (shamt_i),
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .result_o (result_o)
);

// File: tb/sim_alu_fc32.sv
`timescale 1ns/1ps
module sim_alu_fc32;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aluop = 1'b0;
    logic [5:0]  func = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    alu_fc32 u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .aluop_i  (aluop),
        .func_i   (func),
        .shamt_i  (shamt),
        .opa_i    (opa),
        .opb_i    (opb),
        .result_o (result)
    );

    function automatic logic [31:0] model(input logic m, input logic [5:0] f,
                                          input logic [4:0] s, input logic [31:0] a,
                                          input logic [31:0] b);
        if (!m) return a + b;
        case (f)
            6'b100000: return a + b;
            6'b100010: return a - b;
            6'b011000: return a * b;
            6'b011011: begin
                if (b == 0) return 32'hFFFF_FFFF;
                if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
                return $signed(a) / $signed(b);
            end
            6'b001101: return a & b;
            6'b001111: return a | b;
            6'b000011: return b >> s;
            6'b000010: return b << s;
            6'b001011: return ~b;
            default:   return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic m, input logic [5:0] f);
        if (!m) return "R2 mode-add";
        case (f)
            6'b100000, 6'b100010: return "R3 add/sub";
            6'b011000: return "R4 mul";
            6'b011011: return "R5 div";
            6'b001101, 6'b001111: return "R8 and/or";
            6'b000011, 6'b000010: return "R9 shift";
            6'b001011: return "R10 inverse";
            default:   return "R11 unlisted";
        endcase
    endfunction

    task automatic drive(input logic m, input logic [5:0] f, input logic [4:0] s,
                         input logic [31:0] a, input logic [31:0] b, input string tag);
        item_t it;
        @(negedge clk);
        aluop = m; func = f; shamt = s; opa = a; opb = b;
        it.exp = model(m, f, s, a, b);
        it.tag = (tag == "") ? tag_of(m, f) : tag;
        q.push_back(it);
    endtask

    // Monitor: each result is valid one rising edge after its inputs.
    always @(posedge clk) begin
        #2;
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (result !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", it.tag, result, it.exp);
            end
        end
    end

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        logic [5:0]  codes [10];
        codes = '{6'b100000, 6'b100010, 6'b011000, 6'b011011, 6'b001101,
                  6'b001111, 6'b000011, 6'b000010, 6'b001011, 6'b010101};

        // R1: reset value
        opa = 32'h1234_5678; opb = 32'h1111_1111; aluop = 1'b1; func = 6'b001011;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (result !== 32'h0) begin
            errors++;
            $display("FAIL R1 reset: got %h expected %h", result, 32'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: mode low adds whatever the function field holds
        drive(1'b0, 6'b100010, 5'd0, 32'd10, 32'd3, "R2 mode-add over sub code");
        drive(1'b0, 6'b001011, 5'd7, 32'hFFFF_FFFF, 32'd2, "R2 mode-add wrap");
        drive(1'b0, 6'b111111, 5'd1, 32'h8000_0000, 32'h8000_0000, "R2 mode-add unlisted code");
        // R3
        drive(1'b1, 6'b100000, 5'd0, 32'h7FFF_FFFF, 32'd1, "R3 add wrap");
        drive(1'b1, 6'b100010, 5'd0, 32'd3, 32'd10, "R3 sub negative");
        // R4
        drive(1'b1, 6'b011000, 5'd0, 32'hFFFF_FFFD, 32'd7, "R4 mul neg");
        drive(1'b1, 6'b011000, 5'd0, 32'h0001_0001, 32'h0001_0001, "R4 mul low word");
        // R5
        drive(1'b1, 6'b011011, 5'd0, 32'hFFFF_FFF9, 32'd2, "R5 div -7/2");
        drive(1'b1, 6'b011011, 5'd0, 32'd7, 32'hFFFF_FFFE, "R5 div 7/-2");
        drive(1'b1, 6'b011011, 5'd0, 32'd100, 32'd7, "R5 div 100/7");
        // R6, R7
        drive(1'b1, 6'b011011, 5'd0, 32'd55, 32'd0, "R6 div by zero");
        drive(1'b1, 6'b011011, 5'd0, 32'h8000_0000, 32'hFFFF_FFFF, "R7 div wrap");
        // R8
        drive(1'b1, 6'b001101, 5'd0, 32'hF0F0_1234, 32'h0FF0_FF00, "R8 and");
        drive(1'b1, 6'b001111, 5'd0, 32'hF0F0_1234, 32'h0FF0_FF00, "R8 or");
        // R9
        drive(1'b1, 6'b000011, 5'd4, 32'hDEAD_0000, 32'h8000_00F0, "R9 srl 4");
        drive(1'b1, 6'b000011, 5'd31, 32'd0, 32'h8000_0000, "R9 srl 31");
        drive(1'b1, 6'b000010, 5'd0, 32'd0, 32'hA5A5_A5A5, "R9 sll 0");
        drive(1'b1, 6'b000010, 5'd31, 32'd0, 32'h0000_0003, "R9 sll 31");
        // R10
        drive(1'b1, 6'b001011, 5'd0, 32'hFFFF_FFFF, 32'h1234_5678, "R10 inverse");
        // R11
        drive(1'b1, 6'b000000, 5'd0, 32'd5, 32'd6, "R11 code 000000");
        drive(1'b1, 6'b100001, 5'd3, 32'd5, 32'd6, "R11 code 100001");
        drive(1'b1, 6'b111111, 5'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R11 code 111111");

        // R12: held inputs keep the result; then a mixed stream
        drive(1'b1, 6'b100010, 5'd0, 32'd9, 32'd4, "R12 hold first");
        drive(1'b1, 6'b100010, 5'd0, 32'd9, 32'd4, "R12 hold second");
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = (i % 7 == 0) ? 32'd0 : lfsr;
            drive(lfsr[9], codes[i % 10], lfsr[14:10], a, b, "");
        end

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule